// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that counts clocks from its last restart. A 2-bit timeout code picks one of four power-of-two interrupt points. When the count reaches that point, a sticky interrupt flag is set. A fixed gap of further counts later, the block issues a one-clock reset request. Software keeps the system alive by pulsing the restart strobe before the reset point. The restart clears the count and the flag, and it drops any reset that is still pending.

The timeout code is latched only at a restart, or at reset to code 00. A count therefore always runs to the length that was chosen when it began. A power-mode input slows the counting by 16 or by 256. It does this through a small prescaler that is also cleared by the restart, so every stretched timeout is an exact multiple of the full-speed one.

Top module: `wdt_two_stage`

## Requirements
- R1: Out of reset, `irq` and `wdt_rst` are 0 and the latched timeout code is 00 whatever `tmo_sel` holds. Counting starts at the first clock after reset is released.
- R2: With `pwr_sel`=00 and `irq_en`=1, `irq` rises exactly 2^(BASE_EXP+STEP_EXP*c) clocks after the restart edge, where c is the latched code. With the default parameters, codes 00, 01, 10 and 11 give 2^17, 2^20, 2^23 and 2^26 clocks.
- R3: `wdt_rst` pulses exactly GAP counts (default 512) after the interrupt point. This holds whether `irq_en` is set or not.
- R4: `pwr_sel` 00 counts every clock. 01 counts once every 16 clocks. 10 and 11 count once every 256 clocks. Every timeout is stretched by that exact factor measured from the restart.
- R5: A one-clock `restart` clears the count, the flag and any pending reset. After a restart, no `wdt_rst` occurs until a full new timeout plus gap has elapsed.
- R6: The interrupt flag stays set until `irq_clr` or `restart` is applied. If the flag sets in the same cycle as `irq_clr`, setting wins.
- R7: `irq` equals the flag ANDed with `irq_en`. Clearing `irq_en` hides the flag without clearing it.
- R8: `wdt_rst` is high for one clock only, and only when `rst_en` was 1 at the reset point. With `rst_en`=0 the count halts at the reset point. Setting `rst_en` later then raises `wdt_rst` on the next counting clock, after which the count starts again from zero.
- R9: A change of `tmo_sel` during a count has no effect until the next `restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_sel | input | 2 | Timeout code, latched at restart |
| pwr_sel | input | 2 | Count-rate divider: 00 /1, 01 /16, 1x /256 |
| restart | input | 1 | One-clock strobe that restarts the watchdog |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| irq_en | input | 1 | Forwards the flag to `irq` |
| rst_en | input | 1 | Allows the reset request pulse |
| irq | output | 1 | Interrupt output (flag AND enable) |
| wdt_rst | output | 1 | One-clock reset request |

## Verification
The assertions assume that `restart` and `irq_clr` are clean synchronous levels. They also assume that `rst_en` and `irq_en` are driven to known values from the start, since the reset-enable property looks one cycle back at `rst_en`. The bench drives every input at the falling edge and holds each enable steady across a measured window. It pulses the strobes for exactly one cycle. It shrinks the exponents and the gap through parameters so that every timeout fits the run length, without changing any cycle relation.

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int BASE_EXP = 17,
  parameter int STEP_EXP = 3,
  parameter int GAP      = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tmo_sel,
  input  logic [1:0] pwr_sel,
  input  logic       restart,
  input  logic       irq_clr,
  input  logic       irq_en,
  input  logic       rst_en,
  output logic       irq,
  output logic       wdt_rst
);
  localparam int MAXE = BASE_EXP + 3 * STEP_EXP;
  localparam int CW   = MAXE + 2;

  logic [7:0]    pre;
  logic [CW-1:0] cnt;
  logic [1:0]    mode_q;
  logic          flag;

  logic [CW-1:0] lim_irq, lim_rst;
  logic          tick, hit_irq, hit_rst;

  assign lim_irq = CW'(1) << (BASE_EXP + STEP_EXP * int'(mode_q));
  assign lim_rst = lim_irq + CW'(GAP);

  assign tick = (pwr_sel == 2'b00) ? 1'b1 :
                (pwr_sel == 2'b01) ? &pre[3:0] : &pre;

  assign hit_irq = tick && (cnt == lim_irq - CW'(1));
  assign hit_rst = tick && (cnt == lim_rst - CW'(1));

  assign irq = flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      cnt     <= '0;
      mode_q  <= 2'b00;
      flag    <= 1'b0;
      wdt_rst <= 1'b0;
    end else if (restart) begin
      pre     <= '0;
      cnt     <= '0;
      mode_q  <= tmo_sel;
      flag    <= 1'b0;
      wdt_rst <= 1'b0;
    end else begin
      pre     <= pre + 8'd1;
      wdt_rst <= hit_rst && rst_en;
      if (hit_irq)
        flag <= 1'b1;
      else if (irq_clr)
        flag <= 1'b0;
      if (hit_rst) begin
        if (rst_en)
          cnt <= '0;
      end else if (tick) begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

module wdt_two_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       restart,
  input logic       irq_clr,
  input logic       irq_en,
  input logic       rst_en,
  input logic       irq,
  input logic       wdt_rst,
  input logic       flag,
  input logic [1:0] mode_q
);
  // R8
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  // R8
  rst_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(rst_en));
  // R5
  restart_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!wdt_rst && !flag));
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !irq_clr && !restart) |=> flag);
  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(mode_q));
endmodule

bind wdt_two_stage wdt_two_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .irq_clr(irq_clr),
  .irq_en(irq_en), .rst_en(rst_en), .irq(irq), .wdt_rst(wdt_rst),
  .flag(flag), .mode_q(mode_q)
);

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
  localparam int BASE = 5;
  localparam int STEP = 1;
  localparam int GAPC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tmo_sel = 2'b11;
  logic [1:0] pwr_sel = 2'b00;
  logic restart = 1'b0, irq_clr = 1'b0, irq_en = 1'b1, rst_en = 1'b1;
  logic irq, wdt_rst;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdt_two_stage #(.BASE_EXP(BASE), .STEP_EXP(STEP), .GAP(GAPC)) dut (
    .clk(clk), .rst_n(rst_n), .tmo_sel(tmo_sel), .pwr_sel(pwr_sel),
    .restart(restart), .irq_clr(irq_clr), .irq_en(irq_en), .rst_en(rst_en),
    .irq(irq), .wdt_rst(wdt_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  // cycles from now until irq rises (limit-capped)
  task automatic count_irq(output int n);
    n = 0;
    while (!irq && n < 70000) begin
      @(posedge clk); @(negedge clk); n++;
    end
  endtask

  task automatic count_rst(output int n, output bit saw_irq);
    n = 0; saw_irq = 1'b0;
    while (!wdt_rst && n < 70000) begin
      @(posedge clk); @(negedge clk); n++;
      if (irq) saw_irq = 1'b1;
    end
  endtask

  task automatic t_reset();
    int n;
    chk(irq == 1'b0 && wdt_rst == 1'b0, "R1 outputs in reset", {irq, wdt_rst}, 0);
    @(negedge clk); rst_n = 1'b1;
    count_irq(n);
    chk(n == (1 << BASE), "R1 code 00 after reset", n, 1 << BASE);
  endtask

  task automatic t_modes();
    int n; bit s;
    for (int m = 0; m < 4; m++) begin
      tmo_sel = 2'(m);
      pulse_restart();
      count_irq(n);
      chk(n == (1 << (BASE + STEP * m)), "R2 interrupt timeout", n, 1 << (BASE + STEP * m));
      count_rst(n, s);
      chk(n == GAPC, "R3 gap to reset", n, GAPC);
      @(negedge clk);
      chk(wdt_rst == 1'b0, "R8 pulse one cycle", wdt_rst, 0);
    end
  endtask

  task automatic t_gap_noirq();
    int n; bit s;
    tmo_sel = 2'b01; irq_en = 1'b0;
    pulse_restart();
    count_rst(n, s);
    chk(n == (1 << (BASE + STEP)) + GAPC, "R3 reset timing irq disabled", n, (1 << (BASE + STEP)) + GAPC);
    chk(s == 1'b0, "R7 irq masked", s, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R7 flag kept while masked", irq, 1);
  endtask

  task automatic t_pwr();
    int n; bit s;
    tmo_sel = 2'b00; pwr_sel = 2'b01;
    pulse_restart();
    count_irq(n);
    chk(n == 16 * (1 << BASE), "R4 divide by 16", n, 16 * (1 << BASE));
    count_rst(n, s);
    chk(n == 16 * GAPC, "R4 gap divide by 16", n, 16 * GAPC);
    pwr_sel = 2'b10;
    pulse_restart();
    count_irq(n);
    chk(n == 256 * (1 << BASE), "R4 divide by 256 code 10", n, 256 * (1 << BASE));
    pwr_sel = 2'b11;
    pulse_restart();
    count_irq(n);
    chk(n == 256 * (1 << BASE), "R4 divide by 256 code 11", n, 256 * (1 << BASE));
    pwr_sel = 2'b00;
  endtask

  task automatic t_cancel();
    int n; bit seen;
    tmo_sel = 2'b00;
    pulse_restart();
    count_irq(n);
    for (int i = 0; i < GAPC - 3; i++) @(negedge clk);
    pulse_restart();
    chk(irq == 1'b0, "R5 restart clears flag", irq, 0);
    seen = 1'b0;
    for (int i = 0; i < GAPC + 4; i++) begin
      @(negedge clk);
      if (wdt_rst) seen = 1'b1;
    end
    chk(seen == 1'b0, "R5 pending reset cancelled", seen, 0);
    pulse_restart();
    count_irq(n);
    chk(n == (1 << BASE), "R5 fresh count after restart", n, 1 << BASE);
  endtask

  task automatic t_sticky();
    int n;
    tmo_sel = 2'b00;
    pulse_restart();
    count_irq(n);
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(irq == 1'b1, "R6 flag sticky", irq, 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R7 enable masks output", irq, 0);
    irq_en = 1'b1;
    #1;
    chk(irq == 1'b1, "R7 unmask shows flag", irq, 1);
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq == 1'b0, "R6 clear drops flag", irq, 0);
  endtask

  task automatic t_rsten_off();
    int n; bit seen;
    tmo_sel = 2'b00; rst_en = 1'b0;
    pulse_restart();
    seen = 1'b0;
    for (int i = 0; i < (1 << BASE) + GAPC + 40; i++) begin
      @(negedge clk);
      if (wdt_rst) seen = 1'b1;
    end
    chk(seen == 1'b0, "R8 no pulse when disabled", seen, 0);
    rst_en = 1'b1;
    @(negedge clk);
    chk(wdt_rst == 1'b1, "R8 held reset issued on enable", wdt_rst, 1);
    @(negedge clk);
    chk(wdt_rst == 1'b0, "R8 single pulse after hold", wdt_rst, 0);
  endtask

  task automatic t_mode_defer();
    int n;
    tmo_sel = 2'b00;
    pulse_restart();
    for (int i = 0; i < 5; i++) @(negedge clk);
    tmo_sel = 2'b11;
    count_irq(n);
    chk(n + 5 == (1 << BASE), "R9 mode change deferred", n + 5, 1 << BASE);
    pulse_restart();
    count_irq(n);
    chk(n == (1 << (BASE + 3 * STEP)), "R9 new mode after restart", n, 1 << (BASE + 3 * STEP));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_modes();
    t_gap_noirq();
    t_pwr();
    t_cancel();
    t_sticky();
    t_rsten_off();
    t_mode_defer();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule